// File: doc/BRIEF.md
# Four-Lane Alignment-Column Deskew Unit

This block sits behind four 8b/10b character decoders that share one receive clock. Each lane delivers a decoded character (an 8-bit value, a control flag and a valid strobe). Skew between lanes means that characters sent in the same column arrive in different cycles. The idle stream between packets carries an alignment control character in the same column on every lane. The unit uses that shared marker to measure how far each lane leads the others. It then sets each lane's FIFO read point so that all four lanes leave as one column on a single clock edge.

Each lane has a small FIFO. While searching, the unit records where the marker landed in each FIFO. When the last lane has delivered its marker, every read pointer is placed on that lane's own marker. From then on all four FIFOs are read together. The unit confirms alignment on later marker columns, declares lock, and watches the output for columns in which only some lanes carry the marker. Too many such columns in a row drop lock and restart the search. A skew larger than the FIFO can absorb raises a sticky error flag.

Top module: `quad_lane_deskew`

## Requirements
- R1: While reset is low, `locked_o`, `col_valid_o`, `lock_lost_o` and `deskew_err_o` are all 0.
- R2: Only a character with the control flag at 1 and value 0x7C counts as the alignment marker. The value 0x7C with the control flag at 0 is ordinary data. It passes through unchanged and has no effect on lock. Idle fill is 0xBC or 0x1C with the control flag at 1.
- R3: With a lane-to-lane skew of up to 7 character times, each aligned output column holds the characters that were sent in the same column on all lanes. Lane A is index 0; lane i uses `col_data_o[8i+7:8i]` and `col_ctrl_o[i]`. A column appears on the outputs one clock after the edge at which its character on the latest lane was accepted.
- R4: `locked_o` and `col_valid_o` rise at the edge that outputs the second consecutive full marker column after a search. Before that, `col_valid_o` stays 0. While locked, every output column has `col_valid_o` at 1.
- R5: Before lock, an output column that carries the marker on some lanes but not all flushes the FIFOs and restarts the search without asserting lock.
- R6: While locked, a partial marker column does not drop lock by itself, and a full marker column clears the count of partial columns in a row. Three partial marker columns in a row followed by a full one keep lock.
- R7: While locked, the fourth consecutive partial marker column drops `locked_o` and `col_valid_o` at the edge that outputs it. At that same edge `lock_lost_o` pulses for exactly one cycle, the FIFOs are flushed and the search restarts.
- R8: If a lane's marker would be overwritten before the latest lane has delivered its own (a skew of 8 or more), `deskew_err_o` is set. It stays at 1 until reset, and no lock is declared from that marker column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock shared by all lanes |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_data_i | input | 32 | Decoded character per lane, lane i in bits [8i+7:8i] |
| lane_ctrl_i | input | 4 | Control flag per lane |
| lane_valid_i | input | 4 | Character valid strobe per lane |
| col_data_o | output | 32 | Aligned column, lane i in bits [8i+7:8i] |
| col_ctrl_o | output | 4 | Control flags of the aligned column |
| col_valid_o | output | 1 | Column is aligned and lock is held |
| locked_o | output | 1 | Alignment lock state |
| lock_lost_o | output | 1 | One-cycle pulse when lock is dropped |
| deskew_err_o | output | 1 | Sticky flag: skew exceeded FIFO capacity |

## Verification
A character accepted on the most-delayed lane at edge c appears in the output column after edge c+1. The lock, valid and loss outputs change at the same edge as the marker column that decides them. The error flag rises at the edge where an early lane writes its eighth character after its marker. The bench numbers the edges from reset release and derives, for each edge, the input column that must be showing (edge minus largest lane delay minus one). It applies the lock rules to that column to get the expected flags. All outputs are sampled 1 ns after the edge, while inputs change only on the falling edge.

// File: rtl/qld_pkg.sv
package qld_pkg;

  localparam int unsigned CHAR_W = 8;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } align_state_e;

  typedef enum logic [1:0] {
    COL_NONE = 2'd0,
    COL_PART = 2'd1,
    COL_FULL = 2'd2
  } col_class_e;

  // A marker is a control character with the alignment code value.
  function automatic logic is_align_char(input logic [CHAR_W-1:0] d,
                                         input logic              k,
                                         input logic [CHAR_W-1:0] code);
    return k && (d == code);
  endfunction

  function automatic col_class_e classify_column(input logic any_hit,
                                                 input logic all_hit);
    if (all_hit) return COL_FULL;
    if (any_hit) return COL_PART;
    return COL_NONE;
  endfunction

endpackage

// File: rtl/qld_lane_fifo.sv
module qld_lane_fifo
  import qld_pkg::*;
#(
  parameter int unsigned       DEPTH      = 8,
  parameter logic [CHAR_W-1:0] ALIGN_CODE = 8'h7C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              wr_ctrl,
  input  logic              search_en,
  input  logic              clear_seen,
  input  logic              commit,
  input  logic              flush,
  input  logic              rd_en,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_ctrl,
  output logic              rd_is_align,
  output logic              not_empty,
  output logic              seen_next,
  output logic              overflow
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [CHAR_W-1:0] mem_d [DEPTH];
  logic              mem_k [DEPTH];
  logic [PW-1:0]     wp, rp, mpos;
  logic [PW-1:0]     occ, mark_age;
  logic              seen, in_mark, full, wr_ok;

  assign in_mark   = wr_en && is_align_char(wr_data, wr_ctrl, ALIGN_CODE);
  assign occ       = wp - rp;
  assign mark_age  = wp - mpos;
  assign full      = (occ == PW'(DEPTH));
  assign not_empty = (occ != '0);
  // While searching the buffer runs as a ring and may overwrite.
  assign wr_ok     = wr_en && (search_en || !full || rd_en);
  assign seen_next = seen || (search_en && in_mark);
  // The stored marker is about to be overwritten.
  assign overflow  = search_en && seen && wr_en && (mark_age == PW'(DEPTH));

  assign rd_data     = mem_d[rp[AW-1:0]];
  assign rd_ctrl     = mem_k[rp[AW-1:0]];
  assign rd_is_align = is_align_char(rd_data, rd_ctrl, ALIGN_CODE);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem_d[wp[AW-1:0]] <= wr_data;
      mem_k[wp[AW-1:0]] <= wr_ctrl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      mpos <= '0;
      seen <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;

      if (flush)       rp <= wp;
      else if (commit) rp <= seen ? mpos : wp;
      else if (rd_en)  rp <= rp + 1'b1;

      if (clear_seen) begin
        seen <= 1'b0;
      end else if (search_en && in_mark && !seen) begin
        seen <= 1'b1;
        mpos <= wp;
      end
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |-> occ <= PW'(DEPTH));

  assert_commit_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> not_empty);

endmodule

// File: rtl/qld_col_check.sv
module qld_col_check
  import qld_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0] hits,
  input  logic             rd_en,
  output col_class_e       cls
);

  always_comb begin
    if (rd_en) cls = classify_column(|hits, &hits);
    else       cls = COL_NONE;
  end

endmodule

// File: rtl/qld_lock_ctrl.sv
module qld_lock_ctrl
  import qld_pkg::*;
#(
  parameter int unsigned LOCK_COLS  = 2,
  parameter int unsigned MISS_LIMIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic         any_ovf,
  input  logic         rd_en,
  input  col_class_e   col_cls,
  output align_state_e state,
  output logic         lock_next,
  output logic         flush,
  output logic         locked,
  output logic         lock_lost,
  output logic         deskew_err
);

  localparam int unsigned CW = $clog2(LOCK_COLS + 1);
  localparam int unsigned MW = $clog2(MISS_LIMIT + 1);

  align_state_e  state_n;
  logic [CW-1:0] hit_cnt, hit_n;
  logic [MW-1:0] miss_cnt, miss_n;
  logic          lost_n;

  always_comb begin
    state_n = state;
    hit_n   = hit_cnt;
    miss_n  = miss_cnt;
    flush   = 1'b0;
    lost_n  = 1'b0;
    unique case (state)
      ST_SEARCH: begin
        if (commit) begin
          state_n = ST_CONFIRM;
          hit_n   = '0;
        end
      end
      ST_CONFIRM: begin
        if (rd_en && col_cls == COL_FULL) begin
          if (hit_cnt == CW'(LOCK_COLS - 1)) begin
            state_n = ST_LOCKED;
            miss_n  = '0;
          end else begin
            hit_n = hit_cnt + 1'b1;
          end
        end else if (rd_en && col_cls == COL_PART) begin
          state_n = ST_SEARCH;
          flush   = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (rd_en && col_cls == COL_FULL) begin
          miss_n = '0;
        end else if (rd_en && col_cls == COL_PART) begin
          if (miss_cnt == MW'(MISS_LIMIT - 1)) begin
            state_n = ST_SEARCH;
            flush   = 1'b1;
            lost_n  = 1'b1;
          end else begin
            miss_n = miss_cnt + 1'b1;
          end
        end
      end
      default: state_n = ST_SEARCH;
    endcase
  end

  assign lock_next = (state_n == ST_LOCKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_SEARCH;
      hit_cnt    <= '0;
      miss_cnt   <= '0;
      locked     <= 1'b0;
      lock_lost  <= 1'b0;
      deskew_err <= 1'b0;
    end else begin
      state      <= state_n;
      hit_cnt    <= hit_n;
      miss_cnt   <= miss_n;
      locked     <= lock_next;
      lock_lost  <= lost_n;
      deskew_err <= deskew_err || any_ovf;
    end
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deskew_err |=> deskew_err);

  assert_lost_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |-> (!locked && $past(locked)));

  assert_lost_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> !lock_lost);

  assert_lock_via_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(state) == ST_CONFIRM);

endmodule

// File: rtl/quad_lane_deskew.sv
module quad_lane_deskew
  import qld_pkg::*;
#(
  parameter int unsigned       LANES      = 4,
  parameter int unsigned       DEPTH      = 8,
  parameter int unsigned       LOCK_COLS  = 2,
  parameter int unsigned       MISS_LIMIT = 4,
  parameter logic [CHAR_W-1:0] ALIGN_CODE = 8'h7C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*CHAR_W-1:0] lane_data_i,
  input  logic [LANES-1:0]        lane_ctrl_i,
  input  logic [LANES-1:0]        lane_valid_i,
  output logic [LANES*CHAR_W-1:0] col_data_o,
  output logic [LANES-1:0]        col_ctrl_o,
  output logic                    col_valid_o,
  output logic                    locked_o,
  output logic                    lock_lost_o,
  output logic                    deskew_err_o
);

  logic [LANES*CHAR_W-1:0] rd_flat;
  logic [LANES-1:0]        rd_ctrl, hits, not_empty, seen_next, ovf;
  logic                    search_en, commit, any_ovf, clear_seen, rd_en;
  logic                    flush, lock_next;
  align_state_e            state;
  col_class_e              col_cls;

  assign search_en  = (state == ST_SEARCH);
  assign any_ovf    = |ovf;
  assign commit     = search_en && (&seen_next) && !any_ovf;
  assign clear_seen = flush || (search_en && (commit || any_ovf));
  assign rd_en      = !search_en && (&not_empty);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qld_lane_fifo #(
      .DEPTH      (DEPTH),
      .ALIGN_CODE (ALIGN_CODE)
    ) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (lane_valid_i[g]),
      .wr_data     (lane_data_i[g*CHAR_W +: CHAR_W]),
      .wr_ctrl     (lane_ctrl_i[g]),
      .search_en   (search_en),
      .clear_seen  (clear_seen),
      .commit      (commit),
      .flush       (flush),
      .rd_en       (rd_en),
      .rd_data     (rd_flat[g*CHAR_W +: CHAR_W]),
      .rd_ctrl     (rd_ctrl[g]),
      .rd_is_align (hits[g]),
      .not_empty   (not_empty[g]),
      .seen_next   (seen_next[g]),
      .overflow    (ovf[g])
    );
  end

  qld_col_check #(.LANES(LANES)) u_check (
    .hits  (hits),
    .rd_en (rd_en),
    .cls   (col_cls)
  );

  qld_lock_ctrl #(
    .LOCK_COLS  (LOCK_COLS),
    .MISS_LIMIT (MISS_LIMIT)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .any_ovf    (any_ovf),
    .rd_en      (rd_en),
    .col_cls    (col_cls),
    .state      (state),
    .lock_next  (lock_next),
    .flush      (flush),
    .locked     (locked_o),
    .lock_lost  (lock_lost_o),
    .deskew_err (deskew_err_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_data_o  <= '0;
      col_ctrl_o  <= '0;
      col_valid_o <= 1'b0;
    end else begin
      if (rd_en) begin
        col_data_o <= rd_flat;
        col_ctrl_o <= rd_ctrl;
      end
      col_valid_o <= rd_en && lock_next;
    end
  end

  assert_valid_in_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o |-> locked_o);

  assert_no_commit_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_ovf |=> !locked_o);

endmodule

// File: tb/tb_quad_lane_deskew.sv
module tb_quad_lane_deskew;

  localparam int FIRST_MARK = 10;
  localparam int MARK_GAP   = 16;
  localparam logic [7:0] K_ALIGN = 8'h7C;
  localparam logic [7:0] K_IDLE5 = 8'hBC;
  localparam logic [7:0] K_IDLE0 = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lane_data = '0;
  logic [3:0]  lane_ctrl = '0;
  logic [3:0]  lane_valid = '0;
  logic [31:0] col_data_o;
  logic [3:0]  col_ctrl_o;
  logic        col_valid_o, locked_o, lock_lost_o, deskew_err_o;

  always #5 clk = ~clk;

  quad_lane_deskew dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .lane_data_i  (lane_data),
    .lane_ctrl_i  (lane_ctrl),
    .lane_valid_i (lane_valid),
    .col_data_o   (col_data_o),
    .col_ctrl_o   (col_ctrl_o),
    .col_valid_o  (col_valid_o),
    .locked_o     (locked_o),
    .lock_lost_o  (lock_lost_o),
    .deskew_err_o (deskew_err_o)
  );

  int tests = 0;
  int fails = 0;
  int skew [4];
  int bad_lane, bad_first, bad_num;
  logic [31:0] seed_s;
  string cur_case;
  int cur_cyc;
  int m_state, m_hits, m_miss;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (case %s, cycle %0d)",
               req, what, act, exp, cur_case, cur_cyc);
    end
  endtask

  function automatic bit is_mark(input int n);
    return (n >= FIRST_MARK) && (((n - FIRST_MARK) % MARK_GAP) == 0);
  endfunction

  function automatic bit corrupted(input int j);
    return (j >= bad_first) && (j < bad_first + bad_num);
  endfunction

  function automatic logic [31:0] mix(input int n, input int lane);
    logic [31:0] h;
    h = 32'(n) * 32'h9E3779B1;
    h = h ^ (32'(lane + 1) * 32'h85EBCA6B) ^ seed_s;
    h = h ^ (h >> 15);
    h = h * 32'h2C1B3C6D;
    h = h ^ (h >> 13);
    return h;
  endfunction

  // {ctrl, value} sent on a lane in input column n
  function automatic logic [8:0] base_char(input int n, input int lane);
    logic [31:0] h;
    if (is_mark(n)) begin
      if (lane == bad_lane && corrupted((n - FIRST_MARK) / MARK_GAP))
        return {1'b1, K_IDLE5};
      return {1'b1, K_ALIGN};
    end
    if (n >= FIRST_MARK && ((n - FIRST_MARK) % MARK_GAP) == 5 && lane == 1)
      return {1'b0, K_ALIGN};   // R2: marker value as plain data
    h = mix(n, lane);
    if (h[12]) return {1'b1, (h[13] ? K_IDLE5 : K_IDLE0)};
    return {1'b0, h[7:0]};
  endfunction

  task automatic run_case(input string name, input int ncyc, input int err_edge,
                          input string lock_req);
    int maxs, n, j;
    bit full, exp_lost, exp_err;
    logic [8:0] ch;
    cur_case = name;
    maxs = 0;
    for (int i = 0; i < 4; i++) if (skew[i] > maxs) maxs = skew[i];
    m_state = 0; m_hits = 0; m_miss = 0;
    @(negedge clk);
    rst_n = 1'b0; lane_valid = '0; lane_data = '0; lane_ctrl = '0;
    repeat (2) @(negedge clk);
    cur_cyc = -1;
    check(!locked_o && !col_valid_o && !lock_lost_o && !deskew_err_o, "R1",
          "outputs during reset",
          int'({locked_o, col_valid_o, lock_lost_o, deskew_err_o}), 0);
    rst_n = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      cur_cyc = c;
      for (int i = 0; i < 4; i++) begin
        if (c >= skew[i]) begin
          ch = base_char(c - skew[i], i);
          lane_valid[i] = 1'b1;
          lane_ctrl[i]  = ch[8];
          lane_data[8*i +: 8] = ch[7:0];
        end else begin
          lane_valid[i] = 1'b0;
          lane_ctrl[i]  = 1'b0;
          lane_data[8*i +: 8] = '0;
        end
      end
      @(posedge clk);
      #1;
      exp_lost = 1'b0;
      exp_err  = (err_edge >= 0) && (c >= err_edge);
      n = c - maxs - 1;
      if (err_edge < 0 && n >= 0 && is_mark(n)) begin
        j = (n - FIRST_MARK) / MARK_GAP;
        full = !corrupted(j);
        case (m_state)
          0: if (full) begin m_state = 1; m_hits = 1; end
          1: if (full) begin m_state = 2; m_miss = 0; end else m_state = 0;
          default: begin
            if (full) m_miss = 0;
            else begin
              m_miss++;
              if (m_miss == 4) begin m_state = 0; exp_lost = 1'b1; end
            end
          end
        endcase
      end
      check(locked_o == (m_state == 2), lock_req, "locked_o",
            int'(locked_o), int'(m_state == 2));
      check(col_valid_o == (m_state == 2), "R4", "col_valid_o",
            int'(col_valid_o), int'(m_state == 2));
      check(lock_lost_o == exp_lost, "R7", "lock_lost_o",
            int'(lock_lost_o), int'(exp_lost));
      check(deskew_err_o == exp_err, "R8", "deskew_err_o",
            int'(deskew_err_o), int'(exp_err));
      if (m_state == 2 && col_valid_o) begin
        for (int i = 0; i < 4; i++) begin
          ch = base_char(n, i);
          check({col_ctrl_o[i], col_data_o[8*i +: 8]} == ch,
                (!ch[8] && ch[7:0] == K_ALIGN) ? "R2" : "R3",
                $sformatf("lane %0d column", i),
                int'({col_ctrl_o[i], col_data_o[8*i +: 8]}), int'(ch));
        end
      end
      @(negedge clk);
    end
  endtask

  task automatic set_skew(input int a, input int b, input int c, input int d);
    skew[0] = a; skew[1] = b; skew[2] = c; skew[3] = d;
  endtask

  initial begin
    seed_s = $urandom(32'h5EED);
    bad_lane = 0; bad_first = 99; bad_num = 0;

    // R3 R4: no skew, clean stream
    set_skew(0, 0, 0, 0);
    run_case("zero_skew", 110, -1, "R4");

    // R3: maximum correctable skew, lane A latest
    set_skew(7, 0, 3, 5);
    run_case("skew7", 130, -1, "R3");

    // R5: second marker column partial before lock
    set_skew(2, 6, 0, 4);
    bad_lane = 2; bad_first = 1; bad_num = 1;
    run_case("confirm_partial", 90 + 3 * MARK_GAP, -1, "R5");

    // R6: three partial columns while locked keep lock
    set_skew(1, 0, 5, 2);
    bad_lane = 3; bad_first = 3; bad_num = 3;
    run_case("three_partial", FIRST_MARK + 9 * MARK_GAP, -1, "R6");

    // R7: four partial columns drop lock, then relock
    set_skew(0, 4, 4, 7);
    bad_lane = 1; bad_first = 3; bad_num = 4;
    run_case("four_partial", FIRST_MARK + 11 * MARK_GAP, -1, "R7");

    // R8: skew of 8 cannot be absorbed; first overwrite at edge 18
    set_skew(0, 8, 0, 0);
    bad_first = 99; bad_num = 0;
    run_case("skew8", 70, 18, "R8");

    // R1 R8: reset clears the sticky flag, normal operation resumes
    set_skew(3, 3, 0, 1);
    run_case("after_error", 90, -1, "R4");

    // constrained random skews and partial-column runs
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 4; i++) skew[i] = $urandom_range(0, 7);
      seed_s    = $urandom;
      bad_lane  = $urandom_range(0, 3);
      bad_first = $urandom_range(2, 5);
      bad_num   = $urandom_range(0, 4);
      run_case($sformatf("random%0d", k), FIRST_MARK + 12 * MARK_GAP, -1, "R6");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion (case %s)", cur_case);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule